// File: doc/BRIEF.md
# Lookup-Table Perceptron Trigger Evaluator

This block decides whether to accept a detector event by evaluating a small feed-forward network: 55 binary hit inputs, two hidden neurons and one output neuron. No multipliers are used. Each hidden neuron splits the hit vector into 4-bit groups. Each group addresses a small weight table that holds the summed contribution of those four inputs. The per-group values are added and the sum is clamped to a 10-bit signed index. That index reads an activation table, which returns the 8-bit neuron output. The output neuron works the same way: its two inputs are the 8-bit hidden outputs, each of which addresses a 256-entry weight table. Its activated value is compared against a programmable threshold to form a one-bit accept.

The evaluator is fully pipelined. It takes one event per clock and returns the decision a fixed seven cycles after the event's valid strobe, which is 56 ns at 125 MHz. All tables and the threshold are filled through one write port. A write is acted on only while no event is being evaluated. A write made at any other time is dropped and reported on an error bit.

Top module: `lut_nn_trigger`

## Requirements
- R1: Hidden neuron n forms its pre-activation as the two's-complement sum of 14 weight-table entries. Table g is addressed by hits[4g+3:4g], with hits[4g] as the address LSB. Address bit 3 of table 13 is always 0.
- R2: A neuron's pre-activation sum is clamped to the range -512..511. The clamped value, as 10-bit two's-complement bits, is the address into that neuron's activation table.
- R3: A hidden neuron's output is the 8-bit unsigned activation-table entry read at the clamped address.
- R4: The output neuron adds weight table 0 at the address of hidden output 0 to weight table 1 at the address of hidden output 1. It then clamps the sum and looks it up as in R2 and R3.
- R5: accept is 1 exactly when out_valid is 1 and the output activation is greater than or equal to the 8-bit unsigned threshold. Otherwise accept is 0.
- R6: out_valid rises exactly 7 clock cycles after the cycle in which in_valid is sampled high. Events may be sent on consecutive cycles, and each one gets its own result in order.
- R7: Table load encoding:
  - tbl_kind selects the target: 0 is a weight table, 1 is an activation table, 2 is the threshold, and 3 writes nothing.
  - tbl_unit selects the neuron: 0 and 1 are the hidden neurons, 2 is the output neuron.
  - tbl_grp selects which weight table.
  - tbl_addr gives the entry.
  - tbl_wdata carries a 12-bit two's-complement weight, or in bits 7:0 an activation value or threshold.
- R8: A table or threshold write while busy is ignored, and wr_err is 1 in the following cycle. The evaluator is busy when in_valid is high or any event is in stages 1 to 6. A write while idle takes effect and leaves wr_err at 0.
- R9: After synchronous reset, out_valid, accept and wr_err are 0 and the threshold is 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Event strobe, samples hits |
| hits | input | 55 | Binary hit vector |
| tbl_we | input | 1 | Table/threshold write enable |
| tbl_kind | input | 2 | Write target kind (R7) |
| tbl_unit | input | 2 | Neuron selector (R7) |
| tbl_grp | input | 4 | Weight-table selector within a neuron |
| tbl_addr | input | 10 | Table entry address |
| tbl_wdata | input | 12 | Write data |
| out_valid | output | 1 | Decision valid |
| accept | output | 1 | Trigger accept decision |
| wr_err | output | 1 | Rejected-write flag, one cycle after the write |

## Verification
The properties take for granted that reset is held for at least one edge and that in_valid and tbl_we carry known values. They also assume no write is relied on to change a table while an event reads it. The stimulus respects this: it fills every table entry and sets the threshold only after the pipeline has drained. Its only writes during an evaluation are deliberate ones, made to check that they are dropped. Memories are never read for a scored event before they have been written, so the unreset table contents never reach a checked decision.

// File: rtl/lut_nn_pkg.sv
package lut_nn_pkg;
  // register stages inside one neuron: table read, clamp, activation read
  localparam int NEUR_LAT = 3;
  // two neurons in series plus the threshold register
  localparam int EVAL_LAT = 2 * NEUR_LAT + 1;

  typedef enum logic [1:0] {
    TK_WEIGHT = 2'd0,
    TK_ACT    = 2'd1,
    TK_THRESH = 2'd2,
    TK_NONE   = 2'd3
  } tbl_kind_e;
endpackage

// File: rtl/lut_nn_ram.sv
module lut_nn_ram #(
  parameter int AW = 4,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  // simple dual port, registered read: maps to block or distributed RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lut_nn_wrdec.sv
module lut_nn_wrdec
  import lut_nn_pkg::*;
#(
  parameter int N_UNIT = 3,
  parameter int UNIT_W = 2
) (
  input  logic              we,
  input  logic [1:0]        kind,
  input  logic [UNIT_W-1:0] unit,
  input  logic              busy,
  output logic [N_UNIT-1:0] wt_we,
  output logic [N_UNIT-1:0] act_we,
  output logic              thr_we,
  output logic              reject
);
  logic open_w;

  assign open_w = we && !busy;
  assign reject = we && busy;
  assign thr_we = open_w && (kind == TK_THRESH);

  for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
    assign wt_we[u]  = open_w && (kind == TK_WEIGHT) && (unit == UNIT_W'(u));
    assign act_we[u] = open_w && (kind == TK_ACT)    && (unit == UNIT_W'(u));
  end
endmodule

// File: rtl/lut_nn_neuron.sv
module lut_nn_neuron #(
  parameter int N_BITS = 55,
  parameter int GW     = 4,
  parameter int W_WT   = 12,
  parameter int W_IDX  = 10,
  parameter int W_ACT  = 8,
  parameter int GSEL_W = 4,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic [N_BITS-1:0] bits,
  input  logic              wt_we,
  input  logic              act_we,
  input  logic [GSEL_W-1:0] wgrp,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [W_WT-1:0]   wdata,
  output logic [W_ACT-1:0]  act_q
);
  localparam int NGRP  = (N_BITS + GW - 1) / GW;
  localparam int PAD_W = NGRP * GW;
  localparam int SUM_W = W_WT + $clog2(NGRP) + 1;
  localparam logic signed [SUM_W-1:0] IDX_HI = SUM_W'(2 ** (W_IDX - 1) - 1);
  localparam logic signed [SUM_W-1:0] IDX_LO = ~IDX_HI;

  logic [PAD_W-1:0]        padded;
  logic [W_WT-1:0]         contrib [NGRP];
  logic signed [SUM_W-1:0] sum_c;
  logic [W_IDX-1:0]        idx_q;

  // unused top bits of the last group read as zero
  always_comb begin
    padded = '0;
    padded[N_BITS-1:0] = bits;
  end

  // one small table per input group: pre-summed weights of its bits
  for (genvar g = 0; g < NGRP; g++) begin : g_syn
    lut_nn_ram #(.AW(GW), .DW(W_WT)) u_tab (
      .clk   (clk),
      .we    (wt_we && (wgrp == GSEL_W'(g))),
      .waddr (waddr[GW-1:0]),
      .wdata (wdata),
      .raddr (padded[g*GW +: GW]),
      .rdata (contrib[g])
    );
  end

  always_comb begin
    sum_c = '0;
    for (int g = 0; g < NGRP; g++)
      sum_c = sum_c + {{(SUM_W - W_WT){contrib[g][W_WT-1]}}, contrib[g]};
  end

  // clamp into the activation table's signed index range
  always_ff @(posedge clk) begin
    if (sum_c > IDX_HI)      idx_q <= IDX_HI[W_IDX-1:0];
    else if (sum_c < IDX_LO) idx_q <= IDX_LO[W_IDX-1:0];
    else                     idx_q <= sum_c[W_IDX-1:0];
  end

  lut_nn_ram #(.AW(W_IDX), .DW(W_ACT)) u_act (
    .clk   (clk),
    .we    (act_we),
    .waddr (waddr[W_IDX-1:0]),
    .wdata (wdata[W_ACT-1:0]),
    .raddr (idx_q),
    .rdata (act_q)
  );
endmodule

// File: rtl/lut_nn_trigger.sv
module lut_nn_trigger
  import lut_nn_pkg::*;
#(
  parameter int N_IN  = 55,
  parameter int N_HID = 2,
  parameter int GW    = 4,
  parameter int W_WT  = 12,
  parameter int W_IDX = 10,
  parameter int W_ACT = 8,
  localparam int NGRP_H = (N_IN + GW - 1) / GW,
  localparam int GSEL_W = $clog2((NGRP_H > N_HID) ? NGRP_H : N_HID),
  localparam int UNIT_W = $clog2(N_HID + 1),
  localparam int ADDR_W = (W_IDX > W_ACT) ? ((W_IDX > GW) ? W_IDX : GW)
                                          : ((W_ACT > GW) ? W_ACT : GW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [N_IN-1:0]   hits,
  input  logic              tbl_we,
  input  logic [1:0]        tbl_kind,
  input  logic [UNIT_W-1:0] tbl_unit,
  input  logic [GSEL_W-1:0] tbl_grp,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [W_WT-1:0]   tbl_wdata,
  output logic              out_valid,
  output logic              accept,
  output logic              wr_err
);
  localparam int LAT    = EVAL_LAT;
  localparam int N_UNIT = N_HID + 1;
  localparam logic [W_ACT-1:0] THR_RST = W_ACT'(2 ** (W_ACT - 1));

  logic [LAT-1:0]         vld;
  logic                   busy;
  logic [N_UNIT-1:0]      wt_we;
  logic [N_UNIT-1:0]      act_we;
  logic                   thr_we;
  logic                   reject;
  logic [W_ACT-1:0]       thr_q;
  logic [N_HID*W_ACT-1:0] hid_act;
  logic [W_ACT-1:0]       out_act;

  assign busy      = in_valid || (|vld[LAT-2:0]);
  assign out_valid = vld[LAT-1];

  lut_nn_wrdec #(.N_UNIT(N_UNIT), .UNIT_W(UNIT_W)) u_dec (
    .we     (tbl_we),
    .kind   (tbl_kind),
    .unit   (tbl_unit),
    .busy   (busy),
    .wt_we  (wt_we),
    .act_we (act_we),
    .thr_we (thr_we),
    .reject (reject)
  );

  for (genvar h = 0; h < N_HID; h++) begin : g_hid
    lut_nn_neuron #(
      .N_BITS(N_IN), .GW(GW), .W_WT(W_WT), .W_IDX(W_IDX),
      .W_ACT(W_ACT), .GSEL_W(GSEL_W), .ADDR_W(ADDR_W)
    ) u_hid (
      .clk    (clk),
      .bits   (hits),
      .wt_we  (wt_we[h]),
      .act_we (act_we[h]),
      .wgrp   (tbl_grp),
      .waddr  (tbl_addr),
      .wdata  (tbl_wdata),
      .act_q  (hid_act[h*W_ACT +: W_ACT])
    );
  end

  // output neuron: each hidden output addresses its own weight table
  lut_nn_neuron #(
    .N_BITS(N_HID * W_ACT), .GW(W_ACT), .W_WT(W_WT), .W_IDX(W_IDX),
    .W_ACT(W_ACT), .GSEL_W(GSEL_W), .ADDR_W(ADDR_W)
  ) u_out (
    .clk    (clk),
    .bits   (hid_act),
    .wt_we  (wt_we[N_HID]),
    .act_we (act_we[N_HID]),
    .wgrp   (tbl_grp),
    .waddr  (tbl_addr),
    .wdata  (tbl_wdata),
    .act_q  (out_act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      accept <= 1'b0;
      wr_err <= 1'b0;
      thr_q  <= THR_RST;
    end else begin
      vld    <= {vld[LAT-2:0], in_valid};
      accept <= vld[LAT-2] && (out_act >= thr_q);
      wr_err <= reject;
      if (thr_we) thr_q <= tbl_wdata[W_ACT-1:0];
    end
  end
endmodule

// File: rtl/lut_nn_trigger_chk.sv
module lut_nn_trigger_chk
  import lut_nn_pkg::*;
#(
  parameter int W_ACT = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             tbl_we,
  input logic             busy,
  input logic [W_ACT-1:0] thr_q,
  input logic             out_valid,
  input logic             accept,
  input logic             wr_err
);
  localparam int LAT   = EVAL_LAT;
  localparam int AGE_W = $clog2(LAT + 1) + 1;

  logic [AGE_W-1:0] age;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != {AGE_W{1'b1}}) age <= age + 1'b1;
  end

  p_lat_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, LAT));

  p_tput_r6: assert property (@(posedge clk) disable iff (rst)
    ((age >= AGE_W'(LAT)) && $past(in_valid, LAT)) |-> out_valid);

  p_acc_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !accept);

  p_reject_r8: assert property (@(posedge clk) disable iff (rst)
    ((age != '0) && $past(tbl_we && busy)) |-> wr_err);

  p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
    ((age != '0) && wr_err) |-> $past(tbl_we));

  p_thr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ((age != '0) && $past(busy)) |-> $stable(thr_q));

  p_reset_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !accept && !wr_err));
endmodule

bind lut_nn_trigger lut_nn_trigger_chk #(.W_ACT(W_ACT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .tbl_we    (tbl_we),
  .busy      (busy),
  .thr_q     (thr_q),
  .out_valid (out_valid),
  .accept    (accept),
  .wr_err    (wr_err)
);

// File: tb/lut_nn_trigger_test.sv
`timescale 1ns/1ps
module lut_nn_trigger_test;
  localparam int NI = 55, NH = 2, NG = 14, LATB = 7;

  logic        clk = 1'b0, rst = 1'b1, in_valid = 1'b0, tbl_we = 1'b0;
  logic [NI-1:0] hits = '0;
  logic [1:0]  tbl_kind = '0, tbl_unit = '0;
  logic [3:0]  tbl_grp = '0;
  logic [9:0]  tbl_addr = '0;
  logic [11:0] tbl_wdata = '0;
  logic        out_valid, accept, wr_err;

  lut_nn_trigger uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .hits(hits),
    .tbl_we(tbl_we), .tbl_kind(tbl_kind), .tbl_unit(tbl_unit),
    .tbl_grp(tbl_grp), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .out_valid(out_valid), .accept(accept), .wr_err(wr_err)
  );

  always #4 clk = ~clk;

  // bench-side copy of intended table contents
  int wh [NH][NG][16];
  int ah [NH][1024];
  int wo [NH][256];
  int ao [1024];
  int thr = 128;

  int checks = 0, errs = 0, mchecks = 0, merrs = 0;
  bit done = 1'b0;

  function automatic int clamp10(int s);
    if (s > 511) return 511;
    if (s < -512) return -512;
    return s;
  endfunction

  function automatic int out_index(logic [NI-1:0] h);
    int hv [NH];
    int s;
    for (int n = 0; n < NH; n++) begin
      s = 0;
      for (int g = 0; g < NG; g++) s += wh[n][g][int'((h >> (4 * g)) & 55'hF)];
      hv[n] = ah[n][clamp10(s) & 1023];
    end
    s = wo[0][hv[0]] + wo[1][hv[1]];
    return clamp10(s) & 1023;
  endfunction

  function automatic int out_value(logic [NI-1:0] h);
    return ao[out_index(h)];
  endfunction

  // monitor: captures events at the edge, scores them half a cycle after output edge
  int q_exp [$];
  int q_cyc [$];
  int cyc = 0;
  int m_e, m_c;
  always begin
    @(posedge clk);
    cyc++;
    if (!rst && in_valid) begin
      q_exp.push_back((out_value(hits) >= thr) ? 1 : 0);
      q_cyc.push_back(cyc);
    end
    @(negedge clk);
    if (!rst) begin
      if (out_valid) begin
        mchecks++;
        if (q_exp.size() == 0) begin
          merrs++;
          $display("FAIL R6: out_valid=1 with no event pending, expected 0");
        end else begin
          m_e = q_exp.pop_front();
          m_c = q_cyc.pop_front();
          if (int'(accept) != m_e) begin
            merrs++;
            $display("FAIL R5: accept=%0d expected %0d", accept, m_e);
          end
          mchecks++;
          if (cyc - m_c != LATB - 1) begin
            merrs++;
            $display("FAIL R6: latency=%0d expected %0d", cyc - m_c + 1, LATB);
          end
        end
      end else if (accept) begin
        mchecks++;
        merrs++;
        $display("FAIL R5: accept=1 while out_valid=0, expected 0");
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input int kind, input int unit, input int grp, input int addr, input int data);
    @(negedge clk);
    tbl_we = 1'b1; tbl_kind = kind[1:0]; tbl_unit = unit[1:0];
    tbl_grp = grp[3:0]; tbl_addr = addr[9:0]; tbl_wdata = data[11:0];
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic send(input logic [NI-1:0] h);
    @(negedge clk);
    in_valid = 1'b1;
    hits = h;
  endtask

  task automatic stop();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (LATB + 2) @(negedge clk);
  endtask

  task automatic set_thr(input int t);
    load(2, 0, 0, 0, t);
    thr = t;
  endtask

  initial begin
    logic [NI-1:0] p;
    int idx, v, flip;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk("R9 out_valid", int'(out_valid), 0);
    chk("R9 accept", int'(accept), 0);
    chk("R9 wr_err", int'(wr_err), 0);

    // fill model, then load every entry through the port (R7)
    for (int n = 0; n < NH; n++) begin
      for (int g = 0; g < NG; g++)
        for (int a = 0; a < 16; a++)
          wh[n][g][a] = (a == 15) ? ((n == 0) ? 2047 : -2048)
                                  : ((a * 97 + g * 31 + n * 53) % 401) - 200;
      for (int i = 0; i < 1024; i++) ah[n][i] = ((i * 13 + n * 71) ^ (i >> 3)) & 255;
      for (int a = 0; a < 256; a++) wo[n][a] = ((a * 29 + n * 101) % 1201) - 600;
    end
    for (int i = 0; i < 1024; i++) ao[i] = (i * 37 + 11) & 255;

    for (int n = 0; n < NH; n++) begin
      for (int g = 0; g < NG; g++)
        for (int a = 0; a < 16; a++) load(0, n, g, a, wh[n][g][a]);
      for (int i = 0; i < 1024; i++) load(1, n, 0, i, ah[n][i]);
      for (int a = 0; a < 256; a++) load(0, 2, n, a, wo[n][a]);
    end
    for (int i = 0; i < 1024; i++) load(1, 2, 0, i, ao[i]);
    // kind 3 writes nothing: put a value that would flip a decision, check below (R7)
    p = 55'h0;
    idx = out_index(p);
    load(3, 2, 0, idx, (ao[idx] >= thr) ? 0 : 255);
    chk("R8 idle write wr_err", int'(wr_err), 0);

    // R9 default threshold 128, R7 kind-3 no effect: scored by monitor
    send(p); stop(); drain();

    // R1 R2 R3 R4: corner patterns, streamed back to back (R6)
    send('0);
    send({NI{1'b1}});               // R2 clamps hidden sums high and low
    for (int i = 0; i < NI; i++) send(55'(1) << i);
    for (int i = 0; i < NI; i++) send(~(55'(1) << i));
    stop(); drain();

    // R1: every address of every group table, others zero
    for (int g = 0; g < NG; g++)
      for (int a = 0; a < 16; a++)
        if (!(g == NG - 1 && a > 7)) send(55'(a) << (4 * g));
    stop(); drain();

    // R4 R6: random events with irregular gaps
    for (int k = 0; k < 300; k++) begin
      send({$urandom, $urandom});
      if (k % 7 == 3) begin stop(); @(negedge clk); end
    end
    stop(); drain();

    // R5: threshold sweep over all values for one event
    p = 55'h12_3456_789A_BCDE;
    v = out_value(p);
    for (int t = 0; t < 256; t++) begin
      set_thr(t);
      send(p); stop(); drain();
    end
    chk("R5 sweep reference sane", (v >= 0 && v < 256) ? 1 : 0, 1);

    set_thr(128);
    // R8: activation write alongside an event is dropped
    p = 55'h0F_0F0F_0F0F_0F0F;
    idx = out_index(p);
    flip = (ao[idx] >= thr) ? 0 : 255;
    @(negedge clk);
    in_valid = 1'b1; hits = p;
    tbl_we = 1'b1; tbl_kind = 2'd1; tbl_unit = 2'd2; tbl_grp = '0;
    tbl_addr = idx[9:0]; tbl_wdata = flip[11:0];
    @(negedge clk);
    in_valid = 1'b0; tbl_we = 1'b0;
    chk("R8 wr_err after busy write", int'(wr_err), 1);
    @(negedge clk);
    chk("R8 wr_err clears", int'(wr_err), 0);
    drain();
    send(p); stop(); drain();       // monitor expects unchanged table

    // R8: threshold write mid-pipeline is dropped
    v = out_value(p);
    send(p); stop();
    @(negedge clk);
    tbl_we = 1'b1; tbl_kind = 2'd2; tbl_wdata = (v >= thr) ? 12'd255 : 12'd0;
    @(negedge clk);
    tbl_we = 1'b0;
    chk("R8 wr_err mid-pipeline", int'(wr_err), 1);
    drain();
    send(p); stop(); drain();

    chk("R6 no events left pending", q_exp.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs + merrs, checks + mchecks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      $display("FAIL R6 watchdog: run hung, got no completion expected completion");
      $display("Result: errors=%0d of %0d checks", errs + merrs + 1, checks + mchecks + 1);
      $finish;
    end
  end
endmodule